// File: doc/BRIEF.md
# Power-Mode and Wake-Up Controller

This block manages the low-power states of a small microcontroller core. Software writes a byte-wide control register over a simple register bus. The register holds three bits. One takes the CPU clock off-line (halt). One shuts the oscillator down (stop). The third disables the supply-voltage monitor. The block drives an oscillator-enable line, a gated CPU-clock-enable line and a system reset request.

Stop and halt differ in which events end them. Stop ends only on a port 3 interrupt or a USB wake-up signal, and the oscillator is restarted through a combinational path because no clock is running. Halt ends on any of five interrupt lines whose bit is set in a wake-up mask. In halt, the oscillator keeps running or stays off according to the oscillator bit. A permitted wake-up clears both mode bits in hardware.

The block filters a supply-low flag from a comparator. When the monitor is enabled and the flag stays up long enough, the block raises a system reset. A read-only status byte records which of three causes produced the most recent reset: power-on, reset pin or low supply.

Top module: `pwr_wake_ctrl`

## Requirements
- R1: After power-on reset is released, the control register reads 0x00, `osc_en` and `cpu_clk_en` are 1, `sys_rst_req` is 0 and the status register reads 0x01.
- R2: The control register is at address 0, with halt in bit 0, oscillator-off in bit 1 and monitor-disable in bit 7; all other bits read 0. The status register is at address 1 and is read-only: writes to it change nothing. Its bits are bit 0 power-on, bit 1 pin, bit 2 low supply, and exactly one bit is set.
- R3: Writing 1 to the halt bit drops `cpu_clk_en` from the cycle after the write edge. While halted with the oscillator bit at 0, `osc_en` stays 1.
- R4: While the oscillator bit is 1 and no stop wake-up event is present, `osc_en` and `cpu_clk_en` are both 0.
- R5: In halt, an interrupt line (index 0 USB, 1 timer 0, 2 port 3, 3 external 0, 4 external 1) wakes the core only if the same bit of `wake_en` is 1. A masked interrupt leaves `cpu_clk_en` at 0 and the halt bit set.
- R6: In stop, only `irq_req[2]` or `usb_wake` wakes the core, whatever the mask is. Such an event raises `osc_en` combinationally, within the same cycle. A wake-up from stop clears both the oscillator bit and the halt bit.
- R7: A wake event that is raised between clock edges and held clears the mode bits at the fourth rising edge. `cpu_clk_en` is still 0 after the third edge and is 1 after the fourth. This is two synchroniser stages plus a two-cycle wake latency.
- R8: With the monitor enabled, `lvd_low` held high across four consecutive rising edges makes `sys_rst_req` go high after the sixth edge. A shorter pulse never raises it.
- R9: With the monitor-disable bit set, `lvd_low` never raises `sys_rst_req` and leaves the status register unchanged.
- R10: A low-supply reset clears the control register and sets the status register to 0x04.
- R11: While `hwrst_n` is low, `sys_rst_req` is 1 and the control register reads 0x00. After release, the status register reads 0x02.
- R12: Asserting `por_n` low clears the control register and sets the status register to 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| hwrst_n | input | 1 | Reset pin, active low, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| irq_req | input | 5 | Interrupt lines: USB, timer 0, port 3, external 0, external 1 |
| wake_en | input | 5 | Per-line halt wake-up mask |
| usb_wake | input | 1 | USB resume signal (wakes from stop) |
| lvd_low | input | 1 | Comparator flag: supply below threshold |
| osc_en | output | 1 | Oscillator enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| sys_rst_req | output | 1 | System reset request |

## Verification
The bench runs every combination of wake-up mask and interrupt line in halt. It also tries every source in stop, so a design that ignores the mask, or that lets a timer or external interrupt end stop, would wake when it should not. It samples the clock enable on the third and on the fourth edge after the event, which catches a synchroniser or latency off by one. It sweeps supply-low pulses of one to six cycles, which shows a filter that trips on a three-cycle glitch or one that counts one cycle too many. It also checks that a disabled monitor, a reset pin and a power-on reset each leave the cause byte and the control register in the stated state.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
   localparam int SRC_USB  = 0;
   localparam int SRC_TMR0 = 1;
   localparam int SRC_P3   = 2;
   localparam int SRC_EXT0 = 3;
   localparam int SRC_EXT1 = 4;
   localparam int N_SRC    = 5;

   localparam int BIT_HALT = 0;
   localparam int BIT_OSC  = 1;
   localparam int BIT_LVDD = 7;

   localparam int CAUSE_W   = 3;
   localparam int CAUSE_POR = 0;
   localparam int CAUSE_PIN = 1;
   localparam int CAUSE_LVD = 2;
endpackage

// File: rtl/pmc_sync.sv
module pmc_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= d;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[i] <= 1'b0;
               else        chain[i] <= chain[i-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/pmc_lvd_filter.sv
module pmc_lvd_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int HOLD        = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvd_low,
   input  logic enable,
   output logic trip
);
   localparam int CW = $clog2(HOLD + 1);
   localparam logic [CW-1:0] HOLD_V = CW'(HOLD);

   logic          low_s;
   logic [CW-1:0] run_q;

   pmc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(lvd_low), .q(low_s)
   );

   // consecutive-cycle counter, saturating at HOLD
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                 run_q <= '0;
      else if (low_s && enable) begin
         if (run_q != HOLD_V)     run_q <= run_q + 1'b1;
      end else                    run_q <= '0;

   assign trip = enable && (run_q == HOLD_V);
endmodule

// File: rtl/pmc_wake.sv
module pmc_wake #(
   parameter int N_SRC       = 5,
   parameter int SYNC_STAGES = 2,
   parameter int P3_IDX      = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             halt_q,
   input  logic             stop_q,
   input  logic [N_SRC-1:0] irq_req,
   input  logic [N_SRC-1:0] wake_en,
   input  logic             usb_wake,
   output logic             wake_clr,
   output logic             osc_hold
);
   logic stop_evt, halt_evt, wake_raw, pend_q, wake_s, clr_q;

   assign stop_evt = irq_req[P3_IDX] | usb_wake;
   assign halt_evt = |(irq_req & wake_en);
   assign wake_raw = stop_q ? stop_evt : (halt_q & halt_evt);

   // holds a short event until the mode bits are released
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                pend_q <= 1'b0;
      else if (halt_q || stop_q) pend_q <= pend_q | wake_raw;
      else                       pend_q <= 1'b0;

   pmc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(wake_raw | pend_q), .q(wake_s)
   );

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) clr_q <= 1'b0;
      else        clr_q <= wake_s & (halt_q | stop_q);

   assign wake_clr = clr_q;
   // clockless restart path for stop mode
   assign osc_hold = stop_q & (stop_evt | pend_q);
endmodule

// File: rtl/pwr_wake_ctrl.sv
module pwr_wake_ctrl
   import pmc_pkg::*;
#(
   parameter int          ADDR_W      = 4,
   parameter logic [ADDR_W-1:0] CTL_ADDR  = 'h0,
   parameter logic [ADDR_W-1:0] STAT_ADDR = 'h1,
   parameter int          SYNC_STAGES = 2,
   parameter int          LVD_HOLD    = 4
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              hwrst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   input  logic [N_SRC-1:0]  irq_req,
   input  logic [N_SRC-1:0]  wake_en,
   input  logic              usb_wake,
   input  logic              lvd_low,
   output logic              osc_en,
   output logic              cpu_clk_en,
   output logic              sys_rst_req
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (LVD_HOLD < 1) begin : g_bad_hold
         $error("LVD_HOLD must be at least 1");
      end
      if (CTL_ADDR == STAT_ADDR) begin : g_bad_addr
         $error("register addresses must differ");
      end
   endgenerate

   logic               rst_n;
   logic               halt_q, osc_q, lvd_dis_q;
   logic [CAUSE_W-1:0] cause_q;
   logic               pin_s, lvd_trip, wake_clr, osc_hold;
   logic               wr_ctl;
   logic               unused_wdata;

   assign rst_n        = por_n & hwrst_n;
   assign wr_ctl       = reg_wr && (reg_addr == CTL_ADDR);
   assign unused_wdata = ^reg_wdata[6:2];

   pmc_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
      .clk(clk), .rst_n(por_n), .d(~hwrst_n), .q(pin_s)
   );

   pmc_lvd_filter #(.SYNC_STAGES(SYNC_STAGES), .HOLD(LVD_HOLD)) u_lvd (
      .clk(clk), .rst_n(rst_n), .lvd_low(lvd_low),
      .enable(~lvd_dis_q), .trip(lvd_trip)
   );

   pmc_wake #(.N_SRC(N_SRC), .SYNC_STAGES(SYNC_STAGES), .P3_IDX(SRC_P3)) u_wake (
      .clk(clk), .rst_n(rst_n), .halt_q(halt_q), .stop_q(osc_q),
      .irq_req(irq_req), .wake_en(wake_en), .usb_wake(usb_wake),
      .wake_clr(wake_clr), .osc_hold(osc_hold)
   );

   // control register: a wake-up clear overrides a same-cycle write
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         halt_q <= 1'b0; osc_q <= 1'b0; lvd_dis_q <= 1'b0;
      end else if (lvd_trip) begin
         halt_q <= 1'b0; osc_q <= 1'b0; lvd_dis_q <= 1'b0;
      end else begin
         if (wr_ctl) begin
            halt_q    <= reg_wdata[BIT_HALT];
            osc_q     <= reg_wdata[BIT_OSC];
            lvd_dis_q <= reg_wdata[BIT_LVDD];
         end
         if (wake_clr) begin
            halt_q <= 1'b0;
            osc_q  <= 1'b0;
         end
      end

   // reset cause: survives pin and low-supply resets
   always_ff @(posedge clk or negedge por_n)
      if (!por_n)        cause_q <= CAUSE_W'(1 << CAUSE_POR);
      else if (pin_s)    cause_q <= CAUSE_W'(1 << CAUSE_PIN);
      else if (lvd_trip) cause_q <= CAUSE_W'(1 << CAUSE_LVD);

   always_comb begin
      reg_rdata = 8'h00;
      if (reg_addr == CTL_ADDR) begin
         reg_rdata[BIT_HALT] = halt_q;
         reg_rdata[BIT_OSC]  = osc_q;
         reg_rdata[BIT_LVDD] = lvd_dis_q;
      end else if (reg_addr == STAT_ADDR) begin
         reg_rdata[CAUSE_W-1:0] = cause_q;
      end
   end

   assign osc_en      = ~osc_q | osc_hold;
   assign cpu_clk_en  = rst_n & ~lvd_trip & ~halt_q & ~osc_q;
   assign sys_rst_req = ~rst_n | lvd_trip;
endmodule

// File: rtl/pwr_wake_ctrl_chk.sv
module pwr_wake_ctrl_chk #(
   parameter int CAUSE_W = 3
) (
   input logic               clk,
   input logic               por_n,
   input logic               hwrst_n,
   input logic               reg_wr,
   input logic               halt_q,
   input logic               osc_q,
   input logic               lvd_dis_q,
   input logic [CAUSE_W-1:0] cause_q,
   input logic               wake_clr,
   input logic               lvd_trip,
   input logic               osc_en,
   input logic               cpu_clk_en,
   input logic               sys_rst_req
);
   // R3: a halted core never has its clock enabled
   a_r3_halt_gates: assert property (@(posedge clk) disable iff (!por_n || !hwrst_n)
      halt_q |-> !cpu_clk_en);

   // R4: the CPU clock never runs without the oscillator
   a_r4_clk_needs_osc: assert property (@(posedge clk) disable iff (!por_n || !hwrst_n)
      cpu_clk_en |-> osc_en);

   // R5: the halt bit only falls through a write, a wake-up or a low-supply reset
   a_r5_halt_release: assert property (@(posedge clk) disable iff (!por_n || !hwrst_n)
      $fell(halt_q) |-> ($past(reg_wr) || $past(wake_clr) || $past(lvd_trip)));

   // R6: a stop-mode exit also drops the halt bit
   a_r6_stop_exit_clears: assert property (@(posedge clk) disable iff (!por_n || !hwrst_n)
      ($fell(osc_q) && $past(wake_clr)) |-> !halt_q);

   // R8: a supply reset starts only while the monitor is enabled
   a_r8_lvd_needs_enable: assert property (@(posedge clk) disable iff (!por_n || !hwrst_n)
      $rose(sys_rst_req) |-> !$past(lvd_dis_q));

   // R2: the cause byte always holds exactly one flag
   a_r2_cause_onehot: assert property (@(posedge clk) disable iff (!por_n)
      $countones(cause_q) == 1);
endmodule

bind pwr_wake_ctrl pwr_wake_ctrl_chk #(.CAUSE_W(pmc_pkg::CAUSE_W)) u_chk (
   .clk(clk), .por_n(por_n), .hwrst_n(hwrst_n), .reg_wr(reg_wr),
   .halt_q(halt_q), .osc_q(osc_q), .lvd_dis_q(lvd_dis_q), .cause_q(cause_q),
   .wake_clr(wake_clr), .lvd_trip(lvd_trip), .osc_en(osc_en),
   .cpu_clk_en(cpu_clk_en), .sys_rst_req(sys_rst_req)
);

// File: tb/pwr_wake_ctrl_tb_top.sv
module pwr_wake_ctrl_tb_top;
   logic       clk = 1'b0;
   logic       por_n = 1'b0, hwrst_n = 1'b1;
   logic       reg_wr = 1'b0;
   logic [3:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic [4:0] irq_req = '0, wake_en = '0;
   logic       usb_wake = 1'b0, lvd_low = 1'b0;
   logic       osc_en, cpu_clk_en, sys_rst_req;

   int total = 0, bad = 0, cyc = 0;

   always #5 clk = ~clk;

   pwr_wake_ctrl dut_i (
      .clk(clk), .por_n(por_n), .hwrst_n(hwrst_n), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_req(irq_req), .wake_en(wake_en), .usb_wake(usb_wake),
      .lvd_low(lvd_low), .osc_en(osc_en), .cpu_clk_en(cpu_clk_en),
      .sys_rst_req(sys_rst_req)
   );

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         total++; bad++;
         $display("FAIL watchdog: act=%0d exp<=150000", cyc);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: act=0x%0h exp=0x%0h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      tick(1);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic pin_reset();
      logic [7:0] v;
      hwrst_n = 1'b0;
      #1;
      chk(sys_rst_req == 1'b1, "R11 rst_req", int'(sys_rst_req), 1);
      rd(0, v); chk(v == 8'h00, "R11 ctl cleared", int'(v), 0);
      tick(3);
      hwrst_n = 1'b1;
      tick(3);
      rd(1, v); chk(v == 8'h02, "R11 status pin", int'(v), 2);
   endtask

   initial begin
      logic [7:0] v;
      tick(3);
      chk(sys_rst_req == 1'b1, "R12 req during por", int'(sys_rst_req), 1);
      por_n = 1'b1;
      tick(3);

      // R1 reset state
      rd(0, v); chk(v == 8'h00, "R1 ctl", int'(v), 0);
      rd(1, v); chk(v == 8'h01, "R1 status", int'(v), 1);
      chk(osc_en == 1'b1, "R1 osc_en", int'(osc_en), 1);
      chk(cpu_clk_en == 1'b1, "R1 cpu_clk_en", int'(cpu_clk_en), 1);
      chk(sys_rst_req == 1'b0, "R1 rst_req", int'(sys_rst_req), 0);

      // R2 map, reserved bits, read-only status
      wr(1, 8'hFF);
      rd(1, v); chk(v == 8'h01, "R2 status read-only", int'(v), 1);
      wr(0, 8'hFF);
      rd(0, v); chk(v == 8'h83, "R2 ctl fields", int'(v), 8'h83);
      chk(osc_en == 1'b0, "R4 osc off", int'(osc_en), 0);
      chk(cpu_clk_en == 1'b0, "R4 clk off", int'(cpu_clk_en), 0);
      wr(0, 8'h00);
      chk(cpu_clk_en == 1'b1, "R2 clear restores clk", int'(cpu_clk_en), 1);

      // R5/R7/R3: every mask against every interrupt line in halt
      for (int m = 0; m < 32; m++) begin
         for (int s = 0; s < 5; s++) begin
            bit exp_w;
            exp_w = m[s];
            wake_en = 5'(m);
            wr(0, 8'h01);
            chk(cpu_clk_en == 1'b0, "R3 halt gates clk", int'(cpu_clk_en), 0);
            chk(osc_en == 1'b1, "R3 osc runs in halt", int'(osc_en), 1);
            irq_req = 5'(1 << s);
            tick(3);
            chk(cpu_clk_en == 1'b0, "R7 not before edge 4", int'(cpu_clk_en), 0);
            tick(1);
            chk(cpu_clk_en == exp_w, "R5 halt wake mask", int'(cpu_clk_en), int'(exp_w));
            rd(0, v);
            chk(v == (exp_w ? 8'h00 : 8'h01), "R5 halt bit", int'(v), exp_w ? 0 : 1);
            irq_req = '0;
            if (!exp_w) wr(0, 8'h00);
            tick(4);
         end
      end

      // R6: stop-mode sources (0..4 interrupt lines, 5 = usb_wake), all unmasked
      wake_en = 5'h1F;
      for (int s = 0; s < 6; s++) begin
         bit exp_w;
         exp_w = (s == 2) || (s == 5);
         wr(0, (s == 5) ? 8'h03 : 8'h02);
         chk(osc_en == 1'b0, "R4 stop osc", int'(osc_en), 0);
         if (s == 5) usb_wake = 1'b1; else irq_req = 5'(1 << s);
         #1;
         chk(osc_en == exp_w, "R6 async osc restart", int'(osc_en), int'(exp_w));
         tick(3);
         chk(cpu_clk_en == 1'b0, "R7 stop not before edge 4", int'(cpu_clk_en), 0);
         tick(1);
         chk(cpu_clk_en == exp_w, "R6 stop wake source", int'(cpu_clk_en), int'(exp_w));
         rd(0, v);
         chk(v == (exp_w ? 8'h00 : 8'h02), "R6 stop bits", int'(v), exp_w ? 0 : 2);
         irq_req = '0; usb_wake = 1'b0;
         if (!exp_w) wr(0, 8'h00);
         tick(4);
      end

      // R11 pin reset
      wr(0, 8'h81);
      pin_reset();

      // R8/R10: supply-low pulses of 1..6 cycles
      wake_en = '0;
      for (int w = 1; w <= 6; w++) begin
         int first;
         bit exp_t;
         exp_t = (w >= 4);
         first = 0;
         pin_reset();
         wr(0, 8'h01);
         lvd_low = 1'b1;
         for (int e = 1; e <= 9; e++) begin
            tick(1);
            if (e == w) lvd_low = 1'b0;
            if (sys_rst_req && first == 0) first = e;
         end
         chk(first == (exp_t ? 6 : 0), "R8 trip edge", first, exp_t ? 6 : 0);
         tick(3);
         rd(1, v); chk(v == (exp_t ? 8'h04 : 8'h02), "R10 status", int'(v), exp_t ? 4 : 2);
         rd(0, v); chk(v == (exp_t ? 8'h00 : 8'h01), "R10 ctl", int'(v), exp_t ? 0 : 1);
         wr(0, 8'h00);
      end

      // R9 monitor disabled
      pin_reset();
      wr(0, 8'h80);
      begin
         int seen;
         seen = 0;
         lvd_low = 1'b1;
         for (int e = 0; e < 12; e++) begin
            tick(1);
            if (sys_rst_req) seen++;
         end
         lvd_low = 1'b0;
         chk(seen == 0, "R9 no reset when disabled", seen, 0);
      end
      rd(1, v); chk(v == 8'h02, "R9 status kept", int'(v), 2);
      rd(0, v); chk(v == 8'h80, "R9 ctl kept", int'(v), 8'h80);

      // R12 power-on reset
      wr(0, 8'h81);
      por_n = 1'b0;
      #1;
      chk(sys_rst_req == 1'b1, "R12 req", int'(sys_rst_req), 1);
      tick(2);
      por_n = 1'b1;
      tick(3);
      rd(0, v); chk(v == 8'h00, "R12 ctl", int'(v), 0);
      rd(1, v); chk(v == 8'h01, "R12 status", int'(v), 1);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule